// File: doc/BRIEF.md
# Multiplier-Accumulator with Preload

This block multiplies two 16-bit operands and folds the product into a 35-bit accumulator register. The register is split into three output fields: a 3-bit extension, a 16-bit upper field and a 16-bit lower field. Operands and mode controls are captured on an X strobe or a Y strobe. A product strobe then moves the new accumulated value into the result register. All three strobes are clock enables on one clock.

The mode controls pick the operand format (signed or unsigned) and the accumulation mode (overwrite, add, or product minus accumulator). They can also add a rounding constant. The lower-field output shares its pins with the Y operand input. Each field has its own active-low output enable. With the preload control high and all three enables inactive, the product strobe loads the whole register from the port inputs. The tri-state pads are modelled as separate in, out and drive-enable signals.

Top module: `mul_acc_unit`

## Requirements
- R1: A synchronous active-high reset clears the operand registers, the captured controls and the 35-bit result register, so all three output fields read zero.
- R2: A high `x_ld` captures `x_in` and the four mode controls; a high `y_ld` captures `y_in` and the four mode controls. The controls in force are those from the most recent accepted strobe. The product strobe uses the captured values, not the live inputs.
- R3: With the captured `tc_mode` high, both operands are two's complement and the product is sign-extended to 35 bits. With it low, both are unsigned and the product is zero-extended.
- R4: With the captured `acc_mode` low, a product strobe overwrites the result register with the (possibly rounded) product.
- R5: With `acc_mode` high and `sub_mode` low, the result becomes product plus register contents, modulo 2^35.
- R6: With `acc_mode` and `sub_mode` both high, the result becomes product minus register contents, modulo 2^35.
- R7: With the captured `rnd_mode` high, 2^15 (the top bit of the lower field) is added to the product before accumulation.
- R8: `ext_out` carries result bits 34..32, `mid_out` bits 31..16 and `lo_out` bits 15..0.
- R9: A product strobe with `preload` high and `oe_ext_n`, `oe_mid_n`, `oe_lo_n` all high loads `{ext_in, mid_in, y_in}` into the result register.
- R10: A product strobe with `preload` high while any output enable is low leaves the result register unchanged.
- R11: A `y_ld` strobe while `oe_lo_n` is low is ignored: neither the Y operand nor the controls change.
- R12: `lo_oe`, `mid_oe` and `ext_oe` are high exactly when `oe_lo_n`, `oe_mid_n` and `oe_ext_n` respectively are low. Without a product strobe, the result register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| x_ld | input | 1 | X strobe: capture X operand and controls |
| y_ld | input | 1 | Y strobe: capture Y operand and controls |
| p_ld | input | 1 | Product strobe: update the result register |
| x_in | input | 16 | X operand |
| y_in | input | 16 | Y operand, also lower-field preload data |
| tc_mode | input | 1 | Two's complement operands when high |
| acc_mode | input | 1 | Accumulate when high, overwrite when low |
| sub_mode | input | 1 | Product minus register when accumulating |
| rnd_mode | input | 1 | Add 2^15 to the product |
| preload | input | 1 | Load result register from the port inputs |
| oe_lo_n | input | 1 | Lower-field output enable, active low |
| oe_mid_n | input | 1 | Upper-field output enable, active low |
| oe_ext_n | input | 1 | Extension-field output enable, active low |
| mid_in | input | 16 | Upper-field preload data |
| ext_in | input | 3 | Extension-field preload data |
| lo_out | output | 16 | Result bits 15..0 |
| mid_out | output | 16 | Result bits 31..16 |
| ext_out | output | 3 | Result bits 34..32 |
| lo_oe | output | 1 | Drive enable for the lower-field pins |
| mid_oe | output | 1 | Drive enable for the upper-field pins |
| ext_oe | output | 1 | Drive enable for the extension-field pins |

## Verification
The bench builds the block with its default widths: 16-bit operands and a 3-bit extension. At these widths a full-scale unsigned square, a small negative signed product and an all-ones preload followed by an add are all within reach. Together they exercise the sign fill of the extension field and the wrap at 2^35. The same widths let a ported-in preload value be set up exactly, so the subtract and blocked-preload cases start from a known register value.

// File: rtl/mac_pkg.sv
package mac_pkg;
    parameter int OP_W  = 16;
    parameter int EXT_W = 3;
    localparam int PROD_W  = 2 * OP_W;
    localparam int ACC_W   = PROD_W + EXT_W;
    localparam int RND_BIT = OP_W - 1;

    typedef logic [OP_W-1:0]  op_t;
    typedef logic [ACC_W-1:0] acc_t;

    typedef struct packed {
        logic tc;
        logic acc;
        logic sub;
        logic rnd;
    } mode_t;

    // Product of two operands, extended to accumulator width
    function automatic acc_t ext_product(input op_t a, input op_t b, input logic tc);
        logic signed [OP_W:0]     sa;
        logic signed [OP_W:0]     sb;
        logic signed [2*OP_W+1:0] p;
        logic signed [ACC_W-1:0]  w;
        sa = {tc & a[OP_W-1], a};
        sb = {tc & b[OP_W-1], b};
        p  = sa * sb;
        w  = ACC_W'(p);
        return acc_t'(w);
    endfunction
endpackage

// File: rtl/mac_in_stage.sv
module mac_in_stage
    import mac_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  x_ld,
    input  logic  y_ld,
    input  logic  y_open,
    input  op_t   x_in,
    input  op_t   y_in,
    input  mode_t mode_in,
    output op_t   x_q,
    output op_t   y_q,
    output mode_t mode_q
);
    logic y_take;
    assign y_take = y_ld & y_open;

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q    <= '0;
            y_q    <= '0;
            mode_q <= '0;
        end else begin
            if (x_ld)   x_q <= x_in;
            if (y_take) y_q <= y_in;
            if (x_ld || y_take) mode_q <= mode_in;
        end
    end
endmodule

// File: rtl/mac_arith.sv
module mac_arith
    import mac_pkg::*;
(
    input  op_t   x_q,
    input  op_t   y_q,
    input  mode_t mode_q,
    input  acc_t  acc_q,
    output acc_t  next_acc
);
    acc_t prod;
    acc_t prod_r;

    always_comb begin
        prod   = ext_product(x_q, y_q, mode_q.tc);
        prod_r = prod + (acc_t'(mode_q.rnd) << RND_BIT);
        if (!mode_q.acc)
            next_acc = prod_r;
        else if (mode_q.sub)
            next_acc = prod_r - acc_q;
        else
            next_acc = prod_r + acc_q;
    end
endmodule

// File: rtl/mac_result_reg.sv
module mac_result_reg
    import mac_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic p_ld,
    input  logic preload,
    input  logic ports_idle,
    input  acc_t port_word,
    input  acc_t next_acc,
    output acc_t acc_q
);
    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else if (p_ld) begin
            if (!preload)
                acc_q <= next_acc;
            else if (ports_idle)
                acc_q <= port_word;
        end
    end
endmodule

// File: rtl/mul_acc_unit.sv
module mul_acc_unit
    import mac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             x_ld,
    input  logic             y_ld,
    input  logic             p_ld,
    input  logic [OP_W-1:0]  x_in,
    input  logic [OP_W-1:0]  y_in,
    input  logic             tc_mode,
    input  logic             acc_mode,
    input  logic             sub_mode,
    input  logic             rnd_mode,
    input  logic             preload,
    input  logic             oe_lo_n,
    input  logic             oe_mid_n,
    input  logic             oe_ext_n,
    input  logic [OP_W-1:0]  mid_in,
    input  logic [EXT_W-1:0] ext_in,
    output logic [OP_W-1:0]  lo_out,
    output logic [OP_W-1:0]  mid_out,
    output logic [EXT_W-1:0] ext_out,
    output logic             lo_oe,
    output logic             mid_oe,
    output logic             ext_oe
);
    op_t   x_q, y_q;
    mode_t mode_in, mode_q;
    acc_t  acc_q, next_acc, port_word;
    logic  ports_idle;

    assign mode_in    = '{tc: tc_mode, acc: acc_mode, sub: sub_mode, rnd: rnd_mode};
    assign ports_idle = oe_lo_n & oe_mid_n & oe_ext_n;
    assign port_word  = {ext_in, mid_in, y_in};

    mac_in_stage u_in (
        .clk(clk), .rst(rst), .x_ld(x_ld), .y_ld(y_ld), .y_open(oe_lo_n),
        .x_in(x_in), .y_in(y_in), .mode_in(mode_in),
        .x_q(x_q), .y_q(y_q), .mode_q(mode_q)
    );

    mac_arith u_arith (
        .x_q(x_q), .y_q(y_q), .mode_q(mode_q), .acc_q(acc_q), .next_acc(next_acc)
    );

    mac_result_reg u_res (
        .clk(clk), .rst(rst), .p_ld(p_ld), .preload(preload),
        .ports_idle(ports_idle), .port_word(port_word),
        .next_acc(next_acc), .acc_q(acc_q)
    );

    assign lo_out  = acc_q[OP_W-1:0];
    assign mid_out = acc_q[PROD_W-1:OP_W];
    assign ext_out = acc_q[ACC_W-1:PROD_W];
    assign lo_oe   = ~oe_lo_n;
    assign mid_oe  = ~oe_mid_n;
    assign ext_oe  = ~oe_ext_n;
endmodule

// File: rtl/mac_checker.sv
module mac_checker
    import mac_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic p_ld,
    input logic y_ld,
    input logic preload,
    input logic oe_lo_n,
    input logic oe_mid_n,
    input logic oe_ext_n,
    input op_t  y_in,
    input op_t  mid_in,
    input logic [EXT_W-1:0] ext_in,
    input op_t  lo_out,
    input op_t  mid_out,
    input logic [EXT_W-1:0] ext_out,
    input op_t  y_q
);
    acc_t res;
    logic idle;
    assign res  = {ext_out, mid_out, lo_out};
    assign idle = oe_lo_n & oe_mid_n & oe_ext_n;

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> res == '0); // R1
    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        !p_ld |=> $stable(res)); // R12
    AST_PRELOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
        (p_ld && preload && idle) |=> res == $past({ext_in, mid_in, y_in})); // R9
    AST_PRELOAD_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (p_ld && preload && !idle) |=> $stable(res)); // R10
    AST_Y_GATED: assert property (@(posedge clk) disable iff (rst)
        (y_ld && !oe_lo_n) |=> $stable(y_q)); // R11
endmodule

bind mul_acc_unit mac_checker u_chk (
    .clk(clk), .rst(rst), .p_ld(p_ld), .y_ld(y_ld), .preload(preload),
    .oe_lo_n(oe_lo_n), .oe_mid_n(oe_mid_n), .oe_ext_n(oe_ext_n),
    .y_in(y_in), .mid_in(mid_in), .ext_in(ext_in),
    .lo_out(lo_out), .mid_out(mid_out), .ext_out(ext_out), .y_q(y_q)
);

// File: tb/test_mul_acc_unit.sv
module test_mul_acc_unit;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic x_ld = 0, y_ld = 0, p_ld = 0;
    logic [15:0] x_in = 0, y_in = 0, mid_in = 0;
    logic [2:0]  ext_in = 0;
    logic tc_mode = 0, acc_mode = 0, sub_mode = 0, rnd_mode = 0, preload = 0;
    logic oe_lo_n = 1, oe_mid_n = 1, oe_ext_n = 1;
    logic [15:0] lo_out, mid_out;
    logic [2:0]  ext_out;
    logic lo_oe, mid_oe, ext_oe;

    int n_chk = 0, n_bad = 0;
    logic [34:0] mdl = '0;
    localparam logic [34:0] MASK = {35{1'b1}};

    always #5 clk = ~clk;

    mul_acc_unit i_mul_acc_unit (.*);

    function automatic logic [34:0] result();
        return {ext_out, mid_out, lo_out};
    endfunction

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Expected accumulation from the requirement text
    function automatic logic [34:0] model(input logic [34:0] a, input logic [15:0] x,
        input logic [15:0] y, input logic tc, input logic ac, input logic sb, input logic rn);
        longint px, py, p, r;
        px = tc ? longint'($signed(x)) : longint'(x);
        py = tc ? longint'($signed(y)) : longint'(y);
        p  = px * py + (rn ? 64'sd32768 : 64'sd0);
        if (!ac)      r = p;
        else if (sb)  r = p - longint'(a);
        else          r = p + longint'(a);
        return 35'(r) & MASK;
    endfunction

    task automatic op(input logic [15:0] x, input logic [15:0] y,
        input logic tc, input logic ac, input logic sb, input logic rn);
        @(negedge clk);
        x_in = x; y_in = y; tc_mode = tc; acc_mode = ac; sub_mode = sb; rnd_mode = rn;
        oe_lo_n = 1; x_ld = 1; y_ld = 1;
        @(negedge clk);
        x_ld = 0; y_ld = 0; preload = 0; p_ld = 1;
        @(negedge clk);
        p_ld = 0;
        mdl = model(mdl, x, y, tc, ac, sb, rn);
    endtask

    task automatic do_preload(input logic [34:0] v);
        @(negedge clk);
        {ext_in, mid_in, y_in} = v;
        oe_lo_n = 1; oe_mid_n = 1; oe_ext_n = 1; preload = 1; p_ld = 1;
        @(negedge clk);
        p_ld = 0; preload = 0;
        mdl = v;
    endtask

    task automatic t_reset();
        chk("R1 result after reset", result(), 0);
        chk("R12 enables idle", {lo_oe, mid_oe, ext_oe}, 0);
    endtask

    task automatic t_unsigned();
        op(16'hFFFF, 16'hFFFF, 0, 0, 0, 0);
        chk("R3/R4 unsigned square", result(), 35'h0FFFE0001);
        chk("R8 ext field", ext_out, 0);
        chk("R8 mid field", mid_out, 16'hFFFE);
        chk("R8 lo field", lo_out, 16'h0001);
    endtask

    task automatic t_signed();
        op(16'hFFFF, 16'h0002, 1, 0, 0, 0);
        chk("R3 signed -2", result(), 35'h7FFFFFFFE);
        chk("R8 ext sign fill", ext_out, 3'h7);
    endtask

    task automatic t_add();
        op(16'd3, 16'd4, 0, 1, 0, 0);
        chk("R5 add to register", result(), mdl);
        chk("R5 wraps to 10", result(), 35'd10);
    endtask

    task automatic t_sub();
        do_preload(35'd100);
        op(16'd2, 16'd3, 0, 1, 1, 0);
        chk("R6 product minus register", result(), mdl);
        chk("R6 6-100", result(), 35'h7FFFFFFA2);
    endtask

    task automatic t_round();
        op(16'd1, 16'd1, 0, 0, 0, 1);
        chk("R7 rounded product", result(), 35'h8001);
    endtask

    task automatic t_wrap();
        do_preload(35'h7FFFFFFFF);
        chk("R9 preload all ones", result(), 35'h7FFFFFFFF);
        op(16'd1, 16'd1, 0, 1, 0, 0);
        chk("R5 modulo 2^35", result(), 0);
    endtask

    task automatic t_preload_blocked();
        do_preload(35'h5_1234_5678);
        chk("R9 preload fields", result(), 35'h5_1234_5678);
        @(negedge clk);
        {ext_in, mid_in, y_in} = 35'h2_AAAA_5555;
        oe_mid_n = 0; preload = 1; p_ld = 1;
        #1 chk("R12 mid enable", {lo_oe, mid_oe, ext_oe}, 3'b010);
        @(negedge clk);
        p_ld = 0; preload = 0;
        chk("R10 blocked preload", result(), 35'h5_1234_5678);
        oe_mid_n = 1;
    endtask

    task automatic t_ygate();
        op(16'd3, 16'd5, 0, 0, 0, 0);
        chk("R4 overwrite 15", result(), 35'd15);
        @(negedge clk);
        oe_lo_n = 0; y_in = 16'd7; acc_mode = 1; sub_mode = 1; tc_mode = 1; y_ld = 1;
        #1 chk("R12 lo enable", lo_oe, 1);
        @(negedge clk);
        y_ld = 0; oe_lo_n = 1;
        @(negedge clk);
        chk("R12 hold without strobe", result(), 35'd15);
        p_ld = 1;
        @(negedge clk);
        p_ld = 0;
        chk("R11 gated Y strobe ignored", result(), 35'd15);
    endtask

    task automatic t_separate();
        @(negedge clk);
        x_in = 16'hFFFF; tc_mode = 0; acc_mode = 0; sub_mode = 0; rnd_mode = 0; x_ld = 1;
        @(negedge clk);
        x_ld = 0; y_in = 16'd3; tc_mode = 1; y_ld = 1;
        @(negedge clk);
        y_ld = 0; x_in = 16'd9; y_in = 16'd9; tc_mode = 0; p_ld = 1;
        @(negedge clk);
        p_ld = 0;
        chk("R2 latest strobe controls, captured operands", result(), 35'h7FFFFFFFD);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_unsigned();
        t_signed();
        t_add();
        t_sub();
        t_round();
        t_wrap();
        t_preload_blocked();
        t_ygate();
        t_separate();
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        chk("R1 reset clears register", result(), 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule